// File: doc/BRIEF.md
# Function-Code Arithmetic Logic Unit

This block is a purely combinational 32-bit arithmetic logic unit that takes its operation select straight from the 6-bit function field of a register-type instruction, so no intermediate control encoding is needed. Two operands, X and Y, enter alongside the select. The block drives a result word, a signed-overflow flag and an operand-equality flag in the same cycle.

The operation set covers logical and arithmetic shifts, addition and subtraction in trapping and non-trapping forms, bitwise AND and OR, and signed and unsigned set-less-than. It also has two less common operations. The first checks whether the 32-bit operand X reads the same in both directions. The second advances a 16-bit Fibonacci shift-register state held in the low half of X by one step. Any function code outside the defined set gives a zero result with the overflow flag low. A datapath uses the block by wiring the instruction's function field to `funct` and the two register operands to `x` and `y`.

Top module: `alu_funct32`

## Requirements
- R1: Code 0x00 (sll) returns X shifted left by Y[4:0], with zeros filling the low bits. Y[31:5] has no effect.
- R2: Code 0x02 (srl) returns X shifted right by Y[4:0], with zeros filling the high bits.
- R3: Code 0x03 (sra) returns X shifted right by Y[4:0], with copies of X[31] filling the high bits.
- R4: Codes 0x20 (add) and 0x21 (addu) return X+Y modulo 2^32. Codes 0x22 (sub) and 0x23 (subu) return X-Y modulo 2^32. Codes 0x21 and 0x23 never raise the overflow flag.
- R5: The overflow flag is high only for code 0x20 when X+Y falls outside the signed 32-bit range, and only for code 0x22 when X-Y falls outside that range. It is low for every other code.
- R6: Code 0x24 returns X AND Y. Code 0x25 returns X OR Y.
- R7: Code 0x2a returns 1 when X < Y as two's-complement values and 0 otherwise, zero-extended to 32 bits.
- R8: Code 0x2b returns 1 when X < Y as unsigned values and 0 otherwise, zero-extended to 32 bits.
- R9: Code 0x3e returns 1 when X[31:16] equals X[15:0] in reversed bit order (X[16+k] == X[15-k] for every k from 0 to 15), and 0 otherwise.
- R10: Code 0x3f returns {16'b0, f, X[15:1]}, where f = X[0]^X[2]^X[3]^X[5]. X[31:16] and Y have no effect. An all-zero low half stays all zero.
- R11: The equal output is high exactly when X equals Y, whatever the select code.
- R12: Every code not listed in R1 to R10 gives a result of 0 and a low overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 32 | First operand; the state for the shift-register step |
| y | input | 32 | Second operand; bits 4:0 give the shift amount |
| funct | input | 6 | Instruction function code selecting the operation |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of the trapping add or subtract |
| equal | output | 1 | High when x equals y |

## Verification
The block holds no state, so a wrong internal value shows up at the ports after the inputs change, within the same cycle. A fault in the shared adder would corrupt add, subtract and both compare codes at once. A fault in decode would appear as a wrong result, or as overflow raised on a non-trapping or undefined code. The bench sweeps all 64 select codes over fixed operands. It then applies extreme signed values, shift amounts 0 and 31 with non-zero upper Y bits, palindromic and broken patterns, and a zero register state, and then random operands. Every output is compared on every vector.

// File: rtl/alu_funct_pkg.sv
package alu_funct_pkg;

   localparam int FN_W = 6;

   typedef enum logic [FN_W-1:0] {
      FN_SLL  = 6'h00,
      FN_SRL  = 6'h02,
      FN_SRA  = 6'h03,
      FN_ADD  = 6'h20,
      FN_ADDU = 6'h21,
      FN_SUB  = 6'h22,
      FN_SUBU = 6'h23,
      FN_AND  = 6'h24,
      FN_OR   = 6'h25,
      FN_SLT  = 6'h2a,
      FN_SLTU = 6'h2b,
      FN_PAL  = 6'h3e,
      FN_LFSR = 6'h3f
   } alu_fn_e;

   // result source chosen by the decoder
   typedef enum logic [3:0] {
      SRC_NONE,
      SRC_SHIFT,
      SRC_SUM,
      SRC_AND,
      SRC_OR,
      SRC_LT_S,
      SRC_LT_U,
      SRC_PAL,
      SRC_LFSR
   } alu_src_e;

   typedef struct packed {
      alu_src_e src;
      logic     sub;      // adder subtracts
      logic     trap;     // overflow may be reported
      logic     left;     // shift direction
      logic     arith;    // sign fill on right shift
   } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
   import alu_funct_pkg::*;
(
   input  logic [FN_W-1:0] funct,
   output alu_ctl_t        ctl
);
   always_comb begin
      ctl = '{src: SRC_NONE, sub: 1'b0, trap: 1'b0, left: 1'b0, arith: 1'b0};
      case (funct)
         FN_SLL:  begin ctl.src = SRC_SHIFT; ctl.left = 1'b1; end
         FN_SRL:  ctl.src = SRC_SHIFT;
         FN_SRA:  begin ctl.src = SRC_SHIFT; ctl.arith = 1'b1; end
         FN_ADD:  begin ctl.src = SRC_SUM; ctl.trap = 1'b1; end
         FN_ADDU: ctl.src = SRC_SUM;
         FN_SUB:  begin ctl.src = SRC_SUM; ctl.sub = 1'b1; ctl.trap = 1'b1; end
         FN_SUBU: begin ctl.src = SRC_SUM; ctl.sub = 1'b1; end
         FN_AND:  ctl.src = SRC_AND;
         FN_OR:   ctl.src = SRC_OR;
         FN_SLT:  begin ctl.src = SRC_LT_S; ctl.sub = 1'b1; end
         FN_SLTU: begin ctl.src = SRC_LT_U; ctl.sub = 1'b1; end
         FN_PAL:  ctl.src = SRC_PAL;
         FN_LFSR: ctl.src = SRC_LFSR;
         default: ctl.src = SRC_NONE;
      endcase
   end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   input  logic              left,
   input  logic              arith,
   output logic [DATA_W-1:0] dout
);
   if ((1 << SH_W) != DATA_W) begin : g_bad_width
      $error("alu_barrel: DATA_W must be a power of two");
   end

   logic              fill;
   logic [DATA_W-1:0] rev_in;
   logic [DATA_W-1:0] rev_out;
   logic [DATA_W-1:0] stage [SH_W+1];

   assign fill = arith & ~left & din[DATA_W-1];

   // a left shift is a right shift of the bit-reversed word
   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev_in[i]  = din[DATA_W-1-i];
      assign rev_out[i] = stage[SH_W][DATA_W-1-i];
   end

   assign stage[0] = left ? rev_in : din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int STEP = 1 << s;
      assign stage[s+1] = amt[s]
         ? {{STEP{fill}}, stage[s][DATA_W-1:STEP]}
         : stage[s];
   end

   assign dout = left ? rev_out : stage[SH_W];
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              sovf,
   output logic              lt_s,
   output logic              lt_u
);
   logic [DATA_W-1:0] b_eff;
   logic              cout;

   assign b_eff       = b ^ {DATA_W{sub}};
   assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};

   // operands agree in sign (after inversion for subtract) but result does not
   assign sovf = (a[DATA_W-1] == b_eff[DATA_W-1]) && (sum[DATA_W-1] != a[DATA_W-1]);

   // meaningful while sub is high
   assign lt_s = sum[DATA_W-1] ^ sovf;
   assign lt_u = ~cout;
endmodule

// File: rtl/alu_special.sv
module alu_special #(
   parameter int              DATA_W = 32,
   parameter int              LFSR_W = 16,
   parameter logic [LFSR_W-1:0] TAPS = 16'h002D
) (
   input  logic [DATA_W-1:0] x,
   output logic              pal,
   output logic [DATA_W-1:0] lfsr_next
);
   localparam int HALF = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_bad_half
      $error("alu_special: DATA_W must be even");
   end
   if (LFSR_W < 2 || LFSR_W > DATA_W) begin : g_bad_lfsr
      $error("alu_special: LFSR_W out of range");
   end
   if (TAPS == '0) begin : g_bad_taps
      $error("alu_special: TAPS must select at least one bit");
   end

   logic [HALF-1:0] low_rev;
   for (genvar k = 0; k < HALF; k++) begin : g_pal
      assign low_rev[k] = x[HALF-1-k];
   end
   assign pal = (x[DATA_W-1:HALF] == low_rev);

   logic [LFSR_W-1:0] state;
   logic              fb;
   assign state = x[LFSR_W-1:0];
   assign fb    = ^(state & TAPS);

   if (LFSR_W == DATA_W) begin : g_full
      assign lfsr_next = {fb, state[LFSR_W-1:1]};
   end else begin : g_part
      assign lfsr_next = {{(DATA_W-LFSR_W){1'b0}}, fb, state[LFSR_W-1:1]};
   end

   logic unused_hi;
   if (LFSR_W < DATA_W) begin : g_hi
      assign unused_hi = 1'b0;
   end else begin : g_nohi
      assign unused_hi = 1'b0;
   end
endmodule

// File: rtl/alu_funct32.sv
module alu_funct32
   import alu_funct_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LFSR_W = 16
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic [FN_W-1:0]   funct,
   output logic [DATA_W-1:0] result,
   output logic              ovf,
   output logic              equal
);
   localparam int SH_W = $clog2(DATA_W);

   if (DATA_W < 8) begin : g_bad_data
      $error("alu_funct32: DATA_W too small");
   end

   alu_ctl_t          ctl;
   logic [DATA_W-1:0] sh_out;
   logic [DATA_W-1:0] sum;
   logic              sovf;
   logic              lt_s;
   logic              lt_u;
   logic              pal;
   logic [DATA_W-1:0] lfsr_next;

   alu_decode u_dec (
      .funct (funct),
      .ctl   (ctl)
   );

   alu_barrel #(.DATA_W(DATA_W)) u_shift (
      .din   (x),
      .amt   (y[SH_W-1:0]),
      .left  (ctl.left),
      .arith (ctl.arith),
      .dout  (sh_out)
   );

   alu_addsub #(.DATA_W(DATA_W)) u_add (
      .a    (x),
      .b    (y),
      .sub  (ctl.sub),
      .sum  (sum),
      .sovf (sovf),
      .lt_s (lt_s),
      .lt_u (lt_u)
   );

   alu_special #(.DATA_W(DATA_W), .LFSR_W(LFSR_W)) u_spec (
      .x         (x),
      .pal       (pal),
      .lfsr_next (lfsr_next)
   );

   always_comb begin
      case (ctl.src)
         SRC_SHIFT: result = sh_out;
         SRC_SUM:   result = sum;
         SRC_AND:   result = x & y;
         SRC_OR:    result = x | y;
         SRC_LT_S:  result = DATA_W'(lt_s);
         SRC_LT_U:  result = DATA_W'(lt_u);
         SRC_PAL:   result = DATA_W'(pal);
         SRC_LFSR:  result = lfsr_next;
         default:   result = '0;
      endcase
   end

   assign ovf   = ctl.trap & sovf;
   assign equal = (x == y);
endmodule

// File: rtl/alu_funct32_chk.sv
module alu_funct32_chk
   import alu_funct_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LFSR_W = 16
) (
   input logic [DATA_W-1:0] x,
   input logic [DATA_W-1:0] y,
   input logic [FN_W-1:0]   funct,
   input logic [DATA_W-1:0] result,
   input logic              ovf,
   input logic              equal
);
   logic known;
   assign known = funct inside {FN_SLL, FN_SRL, FN_SRA, FN_ADD, FN_ADDU, FN_SUB,
                                FN_SUBU, FN_AND, FN_OR, FN_SLT, FN_SLTU, FN_PAL, FN_LFSR};

   always_comb begin
      if (!known)
         p_undef_zero_r12: assert (result == '0 && !ovf)
            else $error("undefined code gave non-zero output");
      if (ovf)
         p_ovf_code_r5: assert (funct == FN_ADD || funct == FN_SUB)
            else $error("overflow on a non-trapping code");
      if (funct == FN_ADDU || funct == FN_SUBU)
         p_no_overflow_r4: assert (!ovf)
            else $error("non-trapping code raised overflow");
      if (funct == FN_SUB && equal)
         p_equal_sub_r11: assert (result == '0 && !ovf)
            else $error("equal operands did not subtract to zero");
      if (funct == FN_SLT || funct == FN_SLTU || funct == FN_PAL)
         p_bool_result_r7: assert (result[DATA_W-1:1] == '0)
            else $error("boolean result has upper bits set");
      if (funct == FN_LFSR)
         p_lfsr_shape_r10: assert (result[DATA_W-1:LFSR_W] == '0 &&
                                   result[LFSR_W-2:0] == x[LFSR_W-1:1])
            else $error("register step shape wrong");
      if (funct == FN_SLL && y[4:0] == 5'd0)
         p_sll_zero_r1: assert (result == x)
            else $error("zero shift changed the operand");
   end
endmodule

bind alu_funct32 alu_funct32_chk #(.DATA_W(DATA_W), .LFSR_W(LFSR_W)) i_chk (
   .x      (x),
   .y      (y),
   .funct  (funct),
   .result (result),
   .ovf    (ovf),
   .equal  (equal)
);

// File: tb/test_alu_funct32.sv
module test_alu_funct32;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] x = '0;
   logic [31:0] y = '0;
   logic [5:0]  funct = '0;
   logic [31:0] result;
   logic        ovf;
   logic        equal;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_funct32 i_alu_funct32 (
      .x(x), .y(y), .funct(funct),
      .result(result), .ovf(ovf), .equal(equal)
   );

   function automatic string tag_of(input logic [5:0] f);
      case (f)
         6'h00: return "R1";
         6'h02: return "R2";
         6'h03: return "R3";
         6'h20, 6'h21, 6'h22, 6'h23: return "R4";
         6'h24, 6'h25: return "R6";
         6'h2a: return "R7";
         6'h2b: return "R8";
         6'h3e: return "R9";
         6'h3f: return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic model(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic o);
      longint sa;
      longint sb;
      longint s;
      bit     p;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      o  = 1'b0;
      r  = '0;
      case (f)
         6'h00: r = a << b[4:0];
         6'h02: r = a >> b[4:0];
         6'h03: r = $signed(a) >>> b[4:0];
         6'h20, 6'h21: begin
            r = a + b;
            s = sa + sb;
            o = (f == 6'h20) && (s > 64'sd2147483647 || s < -64'sd2147483648);
         end
         6'h22, 6'h23: begin
            r = a - b;
            s = sa - sb;
            o = (f == 6'h22) && (s > 64'sd2147483647 || s < -64'sd2147483648);
         end
         6'h24: r = a & b;
         6'h25: r = a | b;
         6'h2a: r = (sa < sb) ? 32'd1 : 32'd0;
         6'h2b: r = (a < b) ? 32'd1 : 32'd0;
         6'h3e: begin
            p = 1'b1;
            for (int k = 0; k < 16; k++) if (a[16+k] != a[15-k]) p = 1'b0;
            r = p ? 32'd1 : 32'd0;
         end
         6'h3f: r = {16'b0, a[0] ^ a[2] ^ a[3] ^ a[5], a[15:1]};
         default: r = '0;
      endcase
   endtask

   task automatic apply(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] er;
      logic        eo;
      logic        ee;
      bit          bad;
      @(posedge clk);
      funct = f; x = a; y = b;
      model(f, a, b, er, eo);
      ee = (a == b);
      @(negedge clk);
      vectors++;
      bad = 1'b0;
      if (result !== er) begin
         $display("FAIL %s funct=%h x=%h y=%h result actual=%h expected=%h",
                  tag_of(f), f, a, b, result, er);
         bad = 1'b1;
      end
      if (ovf !== eo) begin
         $display("FAIL %s funct=%h x=%h y=%h ovf actual=%b expected=%b",
                  (f == 6'h21 || f == 6'h23) ? "R4" : (f inside {6'h20, 6'h22} ? "R5" : tag_of(f)),
                  f, a, b, ovf, eo);
         bad = 1'b1;
      end
      if (equal !== ee) begin
         $display("FAIL R11 funct=%h x=%h y=%h equal actual=%b expected=%b",
                  f, a, b, equal, ee);
         bad = 1'b1;
      end
      if (bad) miscompares++;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      logic [5:0] f;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // idle state: zero operands, code 0 (R1, R11)
      apply(6'h00, 32'h0, 32'h0);

      // every code over two operand pairs, covers R12 for the undefined codes
      for (int c = 0; c < 64; c++) begin
         apply(6'(c), 32'h8765_4321, 32'h0000_1234);
         apply(6'(c), 32'hF0F0_1234, 32'hF0F0_1234);
      end

      // shifts at 0 and 31, upper Y bits set (R1 R2 R3)
      apply(6'h00, 32'h8000_0001, 32'hFFFF_FFE0);
      apply(6'h00, 32'h0000_0003, 32'h0000_001F);
      apply(6'h02, 32'h8000_0000, 32'hABCD_001F);
      apply(6'h02, 32'hDEAD_BEEF, 32'h0000_0000);
      apply(6'h03, 32'h8000_0000, 32'h0000_001F);
      apply(6'h03, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      apply(6'h03, 32'hC000_0000, 32'h0000_0004);

      // signed overflow corners (R4 R5)
      apply(6'h20, 32'h7FFF_FFFF, 32'h0000_0001);
      apply(6'h21, 32'h7FFF_FFFF, 32'h0000_0001);
      apply(6'h20, 32'h8000_0000, 32'h8000_0000);
      apply(6'h20, 32'hFFFF_FFFF, 32'h0000_0001);
      apply(6'h22, 32'h8000_0000, 32'h0000_0001);
      apply(6'h23, 32'h8000_0000, 32'h0000_0001);
      apply(6'h22, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
      apply(6'h22, 32'h0000_0000, 32'h8000_0000);
      apply(6'h22, 32'hFFFF_FFFF, 32'h8000_0000);

      // compares at the sign boundary (R7 R8)
      apply(6'h2a, 32'h8000_0000, 32'h7FFF_FFFF);
      apply(6'h2b, 32'h8000_0000, 32'h7FFF_FFFF);
      apply(6'h2a, 32'h7FFF_FFFF, 32'h8000_0000);
      apply(6'h2b, 32'h0000_0000, 32'hFFFF_FFFF);
      apply(6'h2a, 32'h0000_0005, 32'h0000_0005);

      // palindromes (R9)
      apply(6'h3e, 32'h8000_0001, 32'h0);
      apply(6'h3e, 32'hB2D0_0B4D, 32'h0);
      apply(6'h3e, 32'h1234_1234, 32'h0);
      apply(6'h3e, 32'hFFFF_FFFF, 32'h0);
      apply(6'h3e, 32'h0000_0001, 32'h0);

      // register step (R10): zero state stays zero, upper X ignored
      apply(6'h3f, 32'hFFFF_0000, 32'h1234_5678);
      apply(6'h3f, 32'h0000_0001, 32'h0);
      apply(6'h3f, 32'h0000_ACE1, 32'h0);

      // random sweep over all codes
      for (int n = 0; n < 3000; n++) begin
         f = 6'($urandom_range(0, 63));
         apply(f, $urandom, (n % 5 == 0) ? 32'($urandom_range(0, 31)) : $urandom);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule